// File: doc/BRIEF.md
# Power-of-two scaler

This unit scales a small unsigned operand by a power of two chosen by an exponent code. The scaling is done with a left shift rather than with a general multiplier. The operand is zero-extended into a wide intermediate and shifted there, so no bit is lost. The upper part of that intermediate is then inspected. When the true product does not fit the output width, the result is clamped to the largest value and a flag reports the overflow.

The result sits in a register that is updated on the rising clock edge. A synchronous reset clears the register and wins over the update enable. While the enable is low, the register keeps its contents. With the defaults, a 4-bit operand is scaled by 2^0 up to 2^7. It is first formed in a 12-bit intermediate and then delivered as an 8-bit result.

Control and data pins are plain signals: there is no handshake. The module on the other side of the block is expected to drive a new operand on every cycle that it raises the enable.

Top module: `pow2_scaler`

## Requirements
- R1: When the enable is high and reset is low, the result register loads the operand multiplied by 2^exp, where exp is the unsigned value of the exponent pin (code 3'b010 gives x4, code 3'b110 gives x64).
- R2: When the product exceeds 255, the result loads 8'hFF and the overflow flag loads 1. This happens when any of bits 11..8 of the 12-bit intermediate is set.
- R3: When the product is 255 or less, the overflow flag loads 0 and the result equals the product exactly. With a 4-bit operand, every exponent from 0 to 4 falls in this case.
- R4: Reset is synchronous and active high. At a clock edge with reset high, the result and the flag become 0, whatever the enable and the data inputs are.
- R5: At a clock edge with reset low and the enable low, the result and the flag keep their previous values, even if the exponent and the operand change.
- R6: The result of an input set appears one clock edge after that input set is sampled: it is visible after the first rising edge and not before.
- R7: An operand of 0 gives a result of 0 with the flag low for every exponent. An exponent of 0 passes the operand through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Update enable; the register loads a new result when this is high |
| exp_i | input | 3 | Unsigned shift exponent |
| op_i | input | 4 | Unsigned operand |
| result_o | output | 8 | Registered scaled result, saturated |
| ovf_o | output | 1 | Registered overflow flag |

## Verification
Two things can happen in the same cycle. Reset and the enable can both be high, and a saturating product can be presented at the edge where reset also arrives. The bench raises reset while the enable is high and an overflowing operand is on the inputs. It expects zero on the result and on the flag one edge later. The next edge, with reset low, must load the saturated value 8'hFF. The bench also changes the inputs while the enable is low. It confirms that the output keeps the last saturated or exact value over several edges.

// File: rtl/pow2_pkg.sv
package pow2_pkg;
  localparam int unsigned DEF_OPW  = 4;
  localparam int unsigned DEF_EXPW = 3;
  localparam int unsigned DEF_OUTW = 8;
endpackage

// File: rtl/pow2_shifter.sv
module pow2_shifter #(
  parameter int unsigned OPW  = pow2_pkg::DEF_OPW,
  parameter int unsigned EXPW = pow2_pkg::DEF_EXPW,
  parameter int unsigned WIDE = 12
) (
  input  logic [OPW-1:0]  op,
  input  logic [EXPW-1:0] sh,
  output logic [WIDE-1:0] wide
);
  // Logarithmic shifter: stage g moves the value by 2^g when bit g is set.
  logic [WIDE-1:0] stage [0:EXPW];

  assign stage[0] = WIDE'(op);

  for (genvar g = 0; g < EXPW; g++) begin : g_stage
    assign stage[g+1] = sh[g] ? (stage[g] << (2**g)) : stage[g];
  end

  assign wide = stage[EXPW];
endmodule

// File: rtl/pow2_clamp.sv
module pow2_clamp #(
  parameter int unsigned WIDE = 12,
  parameter int unsigned OUTW = pow2_pkg::DEF_OUTW
) (
  input  logic [WIDE-1:0] wide,
  output logic [OUTW-1:0] val,
  output logic            ovf
);
  always_comb begin
    ovf = |wide[WIDE-1:OUTW];
    val = ovf ? {OUTW{1'b1}} : wide[OUTW-1:0];
  end
endmodule

// File: rtl/pow2_scaler.sv
module pow2_scaler #(
  parameter int unsigned OPW  = pow2_pkg::DEF_OPW,
  parameter int unsigned EXPW = pow2_pkg::DEF_EXPW,
  parameter int unsigned OUTW = pow2_pkg::DEF_OUTW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [EXPW-1:0] exp_i,
  input  logic [OPW-1:0]  op_i,
  output logic [OUTW-1:0] result_o,
  output logic            ovf_o
);
  localparam int unsigned WIDE    = OUTW + OPW;
  localparam int unsigned SAFE_SH = OUTW - OPW;

  logic [WIDE-1:0] wide;
  logic [OUTW-1:0] sat_val;
  logic            sat_ovf;

  pow2_shifter #(.OPW(OPW), .EXPW(EXPW), .WIDE(WIDE)) u_shift (
    .op(op_i), .sh(exp_i), .wide(wide)
  );

  pow2_clamp #(.WIDE(WIDE), .OUTW(OUTW)) u_clamp (
    .wide(wide), .val(sat_val), .ovf(sat_ovf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      ovf_o    <= 1'b0;
    end else if (en) begin
      result_o <= sat_val;
      ovf_o    <= sat_ovf;
    end
  end

  // R1: a pure shift keeps the number of set bits of the operand.
  assert_shift_keeps_bits_R1: assert property (@(posedge clk) disable iff (rst)
    $countones(wide) == $countones(op_i));

  // R2: a raised flag always comes with the all-ones result.
  assert_sat_value_R2: assert property (@(posedge clk) disable iff (rst)
    ovf_o |-> (result_o == {OUTW{1'b1}}));

  // R3: small exponents can never overflow.
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    (en && (int'(exp_i) <= int'(SAFE_SH))) |=> !ovf_o);

  // R5: with the enable low, the outputs hold.
  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(result_o) && $stable(ovf_o)));

  // R7: a zero operand yields zero.
  assert_zero_op_R7: assert property (@(posedge clk) disable iff (rst)
    (en && op_i == '0) |=> (result_o == '0 && !ovf_o));
endmodule

// File: tb/test_pow2_scaler.sv
`timescale 1ns/1ps
module test_pow2_scaler;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en  = 1'b0;
  logic [2:0] exp_i = '0;
  logic [3:0] op_i  = '0;
  logic [7:0] result_o;
  logic       ovf_o;
  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  pow2_scaler i_pow2_scaler (
    .clk(clk), .rst(rst), .en(en), .exp_i(exp_i), .op_i(op_i),
    .result_o(result_o), .ovf_o(ovf_o)
  );

  // Directed vectors: {exp, op}
  localparam logic [6:0] VEC [0:11] = '{
    {3'd2, 4'd1}, {3'd6, 4'd1}, {3'd0, 4'd15}, {3'd4, 4'd15},
    {3'd5, 4'd8}, {3'd5, 4'd7}, {3'd7, 4'd1}, {3'd7, 4'd2},
    {3'd3, 4'd9}, {3'd1, 4'd0}, {3'd7, 4'd0}, {3'd4, 4'd11}
  };

  task automatic check(input string req, input logic [7:0] er, input logic eo);
    total++;
    if (result_o !== er || ovf_o !== eo) begin
      bad++;
      $display("FAIL %s: result=%h ovf=%b expected result=%h ovf=%b",
               req, result_o, ovf_o, er, eo);
    end
  endtask

  task automatic model(input int e, input int o, output logic [7:0] r, output logic f);
    int p;
    p = o * (1 << e);
    f = (p > 255);
    r = f ? 8'hFF : 8'(p);
  endtask

  task automatic apply(input int e, input int o, input string req);
    logic [7:0] r;
    logic f;
    @(negedge clk);
    en = 1'b1; exp_i = 3'(e); op_i = 4'(o);
    model(e, o, r, f);
    @(negedge clk);
    check(req, r, f);
  endtask

  initial begin
    logic [7:0] held;
    repeat (3) @(negedge clk);
    check("R4 reset state", 8'h00, 1'b0);
    rst = 1'b0;

    // R6: the output changes only after the edge.
    @(negedge clk);
    en = 1'b1; exp_i = 3'd2; op_i = 4'd3;
    #1 check("R6 before edge", 8'h00, 1'b0);
    @(negedge clk);
    check("R6 after edge", 8'd12, 1'b0);

    for (int i = 0; i < 12; i++)
      apply(int'(VEC[i][6:4]), int'(VEC[i][3:0]), "R1 R2 R3 table");

    for (int e = 0; e < 8; e++)
      for (int o = 0; o < 16; o++)
        apply(e, o, (e <= 4) ? "R3 exact sweep" : "R1 R2 sweep");

    apply(0, 13, "R7 unit exponent");
    apply(6, 0, "R7 zero operand");

    // R5: hold a saturated value while the inputs change.
    apply(7, 15, "R2 saturate");
    @(negedge clk);
    en = 1'b0; exp_i = 3'd0; op_i = 4'd1;
    repeat (3) @(negedge clk);
    check("R5 hold saturated", 8'hFF, 1'b1);
    apply(3, 5, "R1 load");
    @(negedge clk);
    en = 1'b0; exp_i = 3'd7; op_i = 4'd15;
    held = 8'd40;
    repeat (2) @(negedge clk);
    check("R5 hold exact", held, 1'b0);

    // R4: reset wins over the enable, even with an overflowing input.
    @(negedge clk);
    rst = 1'b1; en = 1'b1; exp_i = 3'd7; op_i = 4'd15;
    @(negedge clk);
    check("R4 reset priority", 8'h00, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R2 after reset", 8'hFF, 1'b1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: result=%h ovf=%b expected run end", result_o, ovf_o);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule